// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock, using a linear feedback shift register whose feedback taps come from one of four generator polynomials chosen at run time. Every operation is modulo-2. Addition and subtraction are both XOR, with no carries. The register is only as wide as the degree of the chosen polynomial, and that degree is also the length of the check field. The register starts at zero, no output inversion is applied, and bits are processed most significant first.

The engine has two modes. In transmit mode it echoes each data bit to the serial output. Once the bit marked as the last data bit has been taken, it sends the remainder of the data multiplied by X^W and divided by the generator, most significant bit first, directly after the data with no gap. In receive mode it divides the entire arriving frame, check field included, by the same generator. When the frame ends it raises a one-cycle completion strobe and an error flag that is set whenever the remainder is non-zero.

A frame opens with a start strobe. The first bit may arrive in the same cycle as the start strobe, or later. The polynomial and the mode are captured only at the start strobe.

Top module: `crc_serial_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `ser_out`, `ser_valid`, `chk_done` and `crc_err` are all 0.
- R2: In transmit mode (`mode_rx`=0), each accepted data bit appears on `ser_out` with `ser_valid`=1 exactly one cycle after it is accepted, and the bits keep their input order.
- R3: In transmit mode, the cycle after the last data bit is echoed, the engine sends W check bits, most significant first, on consecutive cycles. These bits are the remainder of data·X^W modulo P, with a zero start value and no final XOR. The `poly_sel` codes are:
  - 0 selects X^12+X^11+X^3+X^2+X+1 (W=12)
  - 1 selects X^16+X^15+X^2+1 (W=16)
  - 2 selects X^16+X^12+X^5+1 (W=16)
  - 3 selects the degree-32 polynomial with terms 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0 (W=32)
- R4: In receive mode (`mode_rx`=1), `chk_done` pulses for one cycle, one cycle after the bit marked by `data_last` is accepted. `crc_err` is then 1 exactly when the remainder of the whole frame over the active W bits is non-zero. `ser_valid` stays 0 for the whole frame.
- R5: In receive mode, a frame that was valid before being corrupted by any single-bit error, or by any burst of length W or less, gives `crc_err`=1.
- R6: The start strobe clears the remainder. A frame's result does not depend on earlier frames, and a data bit given in the start cycle is the frame's first bit. A one-bit frame, with start and last in the same cycle, is legal.
- R7: `poly_sel` and `mode_rx` are sampled only in the start cycle. Changing them later in the frame has no effect.
- R8: A bit is accepted only when `bit_valid`=1 and either a frame is open or the start strobe is present. Cycles with `bit_valid`=0 pause the frame without changing it. Bits offered while idle or during the check-bit phase are ignored.
- R9: `crc_err` holds its value until it is cleared by the next start strobe or replaced by the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a frame, clears the remainder, captures selection and mode |
| bit_valid | input | 1 | `bit_in` carries a frame bit this cycle |
| bit_in | input | 1 | Serial frame bit, most significant first |
| data_last | input | 1 | With `bit_valid`, marks the final input bit of the frame |
| poly_sel | input | 2 | Generator polynomial code (see R3) |
| mode_rx | input | 1 | 0 = transmit and append, 1 = receive and check |
| ser_out | output | 1 | Serial output: echoed data, then check bits |
| ser_valid | output | 1 | `ser_out` is valid |
| chk_done | output | 1 | One-cycle strobe: receive check finished |
| crc_err | output | 1 | Non-zero remainder on the last checked frame |

## Verification
The properties assume a fixed input discipline. `data_last` means something only together with `bit_valid`. A frame opens with `frame_start` before, or together with, its first bit. Inputs hold known values once reset is released. The bench drives every input one half-period away from the sampling edge and opens every frame with a start strobe. It also deliberately breaks the secondary rules: it presents bits with no open frame, asserts `data_last` and toggles `bit_valid` during the check-bit phase, and changes the selection inputs mid-frame. These cases exercise the paths that are meant to ignore such input.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int CRC_MAX_W = 32;
    localparam int CRC_CNT_W = $clog2(CRC_MAX_W + 1);

    typedef enum logic [1:0] {
        POLY_C12   = 2'd0,
        POLY_C16   = 2'd1,
        POLY_CCITT = 2'd2,
        POLY_C32   = 2'd3
    } poly_sel_e;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_DATA   = 2'd1,
        FR_APPEND = 2'd2
    } frame_st_e;

    typedef struct packed {
        logic [CRC_MAX_W-1:0] taps;
        logic [CRC_MAX_W-1:0] mask;
        logic [CRC_CNT_W-1:0] width;
    } poly_cfg_t;

    // Bits [w-1:0] set.
    function automatic logic [CRC_MAX_W-1:0] width_mask(input logic [CRC_CNT_W-1:0] w);
        logic [CRC_MAX_W-1:0] m;
        for (int i = 0; i < CRC_MAX_W; i++) begin
            m[i] = (i < int'(w));
        end
        return m;
    endfunction

    // Taps hold the divisor without its leading term.
    function automatic poly_cfg_t poly_lookup(input poly_sel_e sel);
        poly_cfg_t c;
        c.taps  = '0;
        c.width = '0;
        unique case (sel)
            POLY_C12: begin
                c.taps  = 32'h0000_080F;
                c.width = CRC_CNT_W'(12);
            end
            POLY_C16: begin
                c.taps  = 32'h0000_8005;
                c.width = CRC_CNT_W'(16);
            end
            POLY_CCITT: begin
                c.taps  = 32'h0000_1021;
                c.width = CRC_CNT_W'(16);
            end
            default: begin
                c.taps  = 32'h04C1_1DB7;
                c.width = CRC_CNT_W'(32);
            end
        endcase
        c.mask = width_mask(c.width);
        return c;
    endfunction

    // Top active bit of the register for the given mask.
    function automatic logic msb_pick(input logic [CRC_MAX_W-1:0] r,
                                      input logic [CRC_MAX_W-1:0] m);
        return |(r & (m ^ (m >> 1)));
    endfunction

    // One division step: shift in a bit, subtract the divisor if the top falls out as 1.
    function automatic logic [CRC_MAX_W-1:0] lfsr_step(input logic [CRC_MAX_W-1:0] r,
                                                       input logic b,
                                                       input poly_cfg_t c);
        logic fb;
        fb = msb_pick(r, c.mask) ^ b;
        return ((r << 1) ^ (fb ? c.taps : '0)) & c.mask;
    endfunction

endpackage

// File: rtl/crc_poly_latch.sv
module crc_poly_latch
    import crc_eng_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  poly_sel_e sel_in,
    input  logic      mode_in,
    output poly_cfg_t cfg_eff,
    output logic      rx_eff
);

    poly_sel_e sel_q;
    logic      mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= POLY_C12;
            mode_q <= 1'b0;
        end else if (load) begin
            sel_q  <= sel_in;
            mode_q <= mode_in;
        end
    end

    // In the start cycle the fresh selection applies at once.
    always_comb begin
        cfg_eff = poly_lookup(load ? sel_in : sel_q);
        rx_eff  = load ? mode_in : mode_q;
    end

endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
    import crc_eng_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 append_en,
    input  poly_cfg_t            cfg,
    output logic [CRC_MAX_W-1:0] rem_nx,
    output logic                 top_bit
);

    logic [CRC_MAX_W-1:0] rem_q;
    logic [CRC_MAX_W-1:0] base;

    always_comb begin
        base   = clear ? '0 : rem_q;
        rem_nx = base;
        if (shift_en) begin
            rem_nx = lfsr_step(base, shift_bit, cfg);
        end else if (append_en) begin
            // Feedback gated off: plain shift-out of the remainder.
            rem_nx = (rem_q << 1) & cfg.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_nx;
        end
    end

    assign top_bit = msb_pick(rem_q, cfg.mask);

endmodule

// File: rtl/crc_frame_fsm.sv
module crc_frame_fsm
    import crc_eng_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 bit_valid,
    input  logic                 data_last,
    input  logic                 rx_eff,
    input  logic [CRC_CNT_W-1:0] width,
    output logic                 shift_en,
    output logic                 append_en,
    output logic                 chk_fire,
    output logic                 echo_fire,
    output logic                 idle
);

    frame_st_e            st_q, st_n;
    logic [CRC_CNT_W-1:0] cnt_q, cnt_n;
    logic                 take;
    logic                 close;

    always_comb begin
        take      = bit_valid && (frame_start || st_q == FR_DATA);
        close     = take && data_last;
        shift_en  = take;
        append_en = (st_q == FR_APPEND) && !frame_start;
        chk_fire  = close && rx_eff;
        echo_fire = take && !rx_eff;
        idle      = (st_q == FR_IDLE);
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (st_q == FR_APPEND) begin
            cnt_n = cnt_q - CRC_CNT_W'(1);
            if (cnt_q == CRC_CNT_W'(1)) begin
                st_n = FR_IDLE;
            end
        end
        if (frame_start) begin
            st_n = FR_DATA;
        end
        if (close) begin
            if (rx_eff) begin
                st_n = FR_IDLE;
            end else begin
                st_n  = FR_APPEND;
                cnt_n = width;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       data_last,
    input  logic [1:0] poly_sel,
    input  logic       mode_rx,
    output logic       ser_out,
    output logic       ser_valid,
    output logic       chk_done,
    output logic       crc_err
);

    poly_cfg_t            cfg_eff;
    logic                 rx_eff;
    logic [CRC_MAX_W-1:0] rem_nx;
    logic                 top_bit;
    logic                 shift_en;
    logic                 append_en;
    logic                 chk_fire;
    logic                 echo_fire;
    logic                 fsm_idle;
    logic [CRC_CNT_W-1:0] cfg_width;

    assign cfg_width = cfg_eff.width;

    crc_poly_latch u_sel (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_start),
        .sel_in  (poly_sel_e'(poly_sel)),
        .mode_in (mode_rx),
        .cfg_eff (cfg_eff),
        .rx_eff  (rx_eff)
    );

    crc_frame_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_valid   (bit_valid),
        .data_last   (data_last),
        .rx_eff      (rx_eff),
        .width       (cfg_eff.width),
        .shift_en    (shift_en),
        .append_en   (append_en),
        .chk_fire    (chk_fire),
        .echo_fire   (echo_fire),
        .idle        (fsm_idle)
    );

    crc_lfsr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_start),
        .shift_en  (shift_en),
        .shift_bit (bit_in),
        .append_en (append_en),
        .cfg       (cfg_eff),
        .rem_nx    (rem_nx),
        .top_bit   (top_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_out   <= 1'b0;
            ser_valid <= 1'b0;
            chk_done  <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            ser_valid <= echo_fire | append_en;
            ser_out   <= echo_fire ? bit_in : (append_en & top_bit);
            chk_done  <= chk_fire;
            if (chk_fire) begin
                crc_err <= |rem_nx;
            end else if (frame_start) begin
                crc_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk
    import crc_eng_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_start,
    input logic                 bit_valid,
    input logic                 bit_in,
    input logic                 data_last,
    input logic                 mode_rx,
    input logic                 ser_out,
    input logic                 ser_valid,
    input logic                 chk_done,
    input logic                 crc_err,
    input logic                 fsm_idle,
    input logic [CRC_CNT_W-1:0] cfg_width
);

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_valid && !chk_done && !crc_err && !ser_out)); // R1

    AST_TX_ECHO: assert property (@(posedge clk) disable iff (rst)
        (frame_start && bit_valid && !mode_rx) |=> (ser_valid && ser_out == $past(bit_in))); // R2

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> $past(bit_valid && data_last)); // R4

    AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (frame_start && mode_rx) |=> !ser_valid); // R4

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(cfg_width)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fsm_idle && !frame_start) |=> !ser_valid); // R8

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!chk_done && !$past(frame_start)) |-> $stable(crc_err)); // R9

endmodule

bind crc_serial_engine crc_serial_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .bit_valid   (bit_valid),
    .bit_in      (bit_in),
    .data_last   (data_last),
    .mode_rx     (mode_rx),
    .ser_out     (ser_out),
    .ser_valid   (ser_valid),
    .chk_done    (chk_done),
    .crc_err     (crc_err),
    .fsm_idle    (fsm_idle),
    .cfg_width   (cfg_width)
);

// File: tb/tb_crc_serial_engine.sv
`timescale 1ns/1ps
module tb_crc_serial_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       data_last = 1'b0;
    logic [1:0] poly_sel = 2'd0;
    logic       mode_rx = 1'b0;
    logic       ser_out;
    logic       ser_valid;
    logic       chk_done;
    logic       crc_err;

    always #2 clk = ~clk;

    crc_serial_engine dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid),
        .bit_in(bit_in), .data_last(data_last), .poly_sel(poly_sel), .mode_rx(mode_rx),
        .ser_out(ser_out), .ser_valid(ser_valid), .chk_done(chk_done), .crc_err(crc_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bit fr  [0:399];
    int fr_len;
    bit cap [0:399];
    int cap_n = 0;
    bit got_done, got_err, done_after;

    always @(negedge clk) begin
        if (ser_valid && cap_n < 400) begin
            cap[cap_n] = ser_out;
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pw(input int sel);
        return (sel == 0) ? 12 : (sel == 3) ? 32 : 16;
    endfunction

    function automatic logic [32:0] pgen(input int sel);
        case (sel)
            0:       return 33'h0_0000_180F;
            1:       return 33'h0_0001_8005;
            2:       return 33'h0_0001_1021;
            default: return 33'h1_04C1_1DB7;
        endcase
    endfunction

    // Long division of fr[0..len-1] * X^w by the generator.
    function automatic logic [31:0] ref_rem(input int sel, input int len);
        bit wk [0:399];
        int w;
        logic [32:0] g;
        logic [31:0] r;
        w = pw(sel);
        g = pgen(sel);
        for (int i = 0; i < 400; i++) wk[i] = 1'b0;
        for (int i = 0; i < len; i++) wk[i] = fr[i];
        for (int i = 0; i < len; i++) begin
            if (wk[i]) begin
                for (int j = 0; j <= w; j++) wk[i+j] = wk[i+j] ^ g[w-j];
            end
        end
        r = '0;
        for (int j = 0; j < w; j++) r[w-1-j] = wk[len+j];
        return r;
    endfunction

    task automatic load_digits();
        for (int k = 0; k < 9; k++) begin
            logic [7:0] by;
            by = 8'h31 + 8'(k);
            for (int b = 0; b < 8; b++) fr[k*8+b] = by[7-b];
        end
        fr_len = 72;
    endtask

    task automatic append_rem(input int sel);
        logic [31:0] r;
        int w;
        w = pw(sel);
        r = ref_rem(sel, fr_len);
        for (int j = 0; j < w; j++) fr[fr_len+j] = r[w-1-j];
        fr_len = fr_len + w;
    endtask

    task automatic idle_cycles(input int n);
        frame_start = 1'b0; bit_valid = 1'b0; data_last = 1'b0; bit_in = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // gap: idle cycles inside the frame; swap: flip selection after bit 0;
    // noise: bits offered during the check-bit phase.
    task automatic send(input int sel, input bit rx, input bit gap, input bit swap, input bit noise);
        cap_n = 0;
        poly_sel = 2'(sel);
        mode_rx = rx;
        for (int i = 0; i < fr_len; i++) begin
            frame_start = (i == 0);
            bit_valid = 1'b1;
            bit_in = fr[i];
            data_last = (i == fr_len - 1);
            @(negedge clk);
            if (i == 0 && swap) begin
                poly_sel = ~poly_sel;
                mode_rx = ~mode_rx;
            end
            if (gap && (i % 3 == 1) && i != fr_len - 1) begin
                bit_valid = 1'b0; frame_start = 1'b0; data_last = 1'b0;
                @(negedge clk);
            end
        end
        got_done = chk_done;
        got_err = crc_err;
        frame_start = 1'b0;
        if (noise) begin
            for (int i = 0; i < 36; i++) begin
                bit_valid = 1'b1;
                bit_in = 1'(i % 2);
                data_last = 1'(i % 5 == 0);
                @(negedge clk);
            end
        end else begin
            bit_valid = 1'b0; data_last = 1'b0;
            @(negedge clk);
        end
        done_after = chk_done;
        idle_cycles(40);
        poly_sel = 2'(sel);
        mode_rx = rx;
    endtask

    task automatic expect_tx(input int sel, input int dlen, input string req);
        int w;
        int bad;
        logic [31:0] r, got;
        w = pw(sel);
        r = ref_rem(sel, dlen);
        check(cap_n == dlen + w, req, "serial bit count", 32'(cap_n), 32'(dlen + w));
        bad = 0;
        for (int i = 0; i < dlen && i < cap_n; i++) if (cap[i] != fr[i]) bad++;
        check(bad == 0, "R2", "echoed data mismatches", 32'(bad), 0);
        got = '0;
        for (int j = 0; j < w && dlen + j < cap_n; j++) got[w-1-j] = cap[dlen+j];
        check(got == r, req, "appended check bits", got, r);
    endtask

    task automatic t_reset();
        check(!ser_valid && !chk_done && !crc_err && !ser_out, "R1", "outputs after reset",
              {28'd0, ser_out, ser_valid, chk_done, crc_err}, 0);
    endtask

    task automatic t_tx(input int sel);
        load_digits();
        send(sel, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_tx(sel, 72, "R3");
    endtask

    task automatic t_known_answers();
        logic [31:0] got;
        load_digits();
        send(2, 1'b0, 1'b0, 1'b0, 1'b0);
        got = '0;
        for (int j = 0; j < 16; j++) got[15-j] = cap[72+j];
        check(got == 32'h31C3, "R3", "degree-16 code 2 digit string", got, 32'h31C3);
        send(1, 1'b0, 1'b0, 1'b0, 1'b0);
        got = '0;
        for (int j = 0; j < 16; j++) got[15-j] = cap[72+j];
        check(got == 32'hFEE8, "R3", "degree-16 code 1 digit string", got, 32'hFEE8);
    endtask

    task automatic t_rx_clean(input int sel);
        load_digits();
        append_rem(sel);
        send(sel, 1'b1, 1'b0, 1'b0, 1'b0);
        check(got_done && !done_after, "R4", "done single pulse", {30'd0, got_done, done_after}, 32'h2);
        check(!got_err, "R4", "clean frame error flag", 32'(got_err), 0);
        check(cap_n == 0, "R4", "serial output in receive", 32'(cap_n), 0);
    endtask

    task automatic t_rx_flip(input int sel, input int pos);
        load_digits();
        append_rem(sel);
        fr[pos] = ~fr[pos];
        send(sel, 1'b1, 1'b0, 1'b0, 1'b0);
        check(got_done && got_err, "R5", "single flip detected", {30'd0, got_done, got_err}, 32'h3);
    endtask

    task automatic t_rx_burst(input int sel, input int start);
        int w;
        w = pw(sel);
        load_digits();
        append_rem(sel);
        for (int i = 0; i < w; i++) fr[start+i] = ~fr[start+i];
        send(sel, 1'b1, 1'b0, 1'b0, 1'b0);
        check(got_err, "R5", "full-width burst detected", 32'(got_err), 1);
    endtask

    task automatic t_fresh_start();
        t_rx_flip(3, 5);
        load_digits();
        send(2, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_tx(2, 72, "R6");
        fr[0] = 1'b1;
        fr_len = 1;
        send(2, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_tx(2, 1, "R6");
        fr[0] = 1'b1;
        fr_len = 1;
        append_rem(0);
        send(0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(got_done && !got_err, "R6", "short receive frame", {30'd0, got_done, got_err}, 32'h2);
    endtask

    task automatic t_sel_midframe();
        load_digits();
        send(2, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_tx(2, 72, "R7");
        load_digits();
        append_rem(0);
        send(0, 1'b1, 1'b0, 1'b1, 1'b0);
        check(got_done && !got_err && cap_n == 0, "R7", "receive with swapped select",
              {29'd0, got_done, got_err, cap_n != 0}, 32'h4);
    endtask

    task automatic t_ignored_bits();
        load_digits();
        send(3, 1'b0, 1'b1, 1'b0, 1'b1);
        expect_tx(3, 72, "R8");
        cap_n = 0;
        for (int i = 0; i < 6; i++) begin
            bit_valid = 1'b1; bit_in = 1'b1; data_last = 1'(i == 5); frame_start = 1'b0;
            @(negedge clk);
            check(!chk_done, "R8", "done while idle", 32'(chk_done), 0);
        end
        idle_cycles(2);
        check(cap_n == 0, "R8", "output while idle", 32'(cap_n), 0);
    endtask

    task automatic t_err_hold();
        t_rx_flip(1, 40);
        check(crc_err, "R9", "flag held after frame", 32'(crc_err), 1);
        frame_start = 1'b1; bit_valid = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        check(!crc_err, "R9", "flag cleared by start", 32'(crc_err), 0);
        idle_cycles(2);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!ser_valid && !chk_done && !crc_err, "R1", "outputs during reset",
              {29'd0, ser_valid, chk_done, crc_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        for (int s = 0; s < 4; s++) t_tx(s);
        t_known_answers();
        for (int s = 0; s < 4; s++) t_rx_clean(s);
        t_rx_flip(0, 0);
        t_rx_flip(2, 80);
        t_rx_burst(0, 30);
        t_rx_burst(3, 60);
        t_rx_burst(1, 72);
        t_fresh_start();
        t_sel_midframe();
        t_ignored_bits();
        t_err_hold();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule